// File: doc/BRIEF.md
# Multi-Service Channel Multiplexer

This block lets several request services share one fixed-width word channel. Each service offers a message of one or more words. On the send side, an arbiter picks one waiting service and emits one header word naming that service and its word count. It then forwards that service's payload words in order. No other service can use the channel until the last payload word has gone out.

A parameter selects the arbitration policy at build time. Under static priority the lowest-numbered waiting service wins. Under rotating priority the search starts just after the service that was granted last.

The receive side works in the other direction. It reads a header from the incoming channel and steers the payload words that follow to the named service. It then treats the next word as a new header. Both directions use valid/ready handshakes and add no buffering. All paths through the block are combinational, so a word crosses it in the cycle it is offered.

Top module: `svc_chan_mux`

## Requirements
- R1: After reset, `co_valid` is low while no service requests, all `in_ready` bits are low, all `out_valid` bits are low, and `ci_ready` is high, because the receiver is waiting for a header.
- R2: A header word carries the service index in bits [11:8] and the message word count in bits [7:0]. All higher bits are zero. The header is sent before the payload words of its message.
- R3: After a header is accepted, exactly the number of words it announces are forwarded. They come from the granted service only, in the order that service presents them. `in_ready` is asserted toward at most one service, and only while the channel is ready.
- R4: While a message is in progress, the grant stays with its service until the last payload word is taken, even when a higher-priority service starts requesting.
- R5: With static arbitration, the header that is offered names the lowest-indexed service whose `in_valid` is high.
- R6: With rotating arbitration, after service k has been granted, the next header names the first requesting service in the order k+1, k+2, …, wrapping modulo the service count. After reset the search starts at service 0.
- R7: On the receive side, a payload word is presented only on the `out_valid` bit of the service named in the current header. `out_data` equals the incoming word, and `out_last` is high on the final payload word.
- R8: The incoming word after the final payload word is taken as a new header. A header with a count of zero is followed directly by another header.
- R9: The payload of a header whose service index is not below the service count is consumed with `ci_ready` high and is delivered to no service.
- R10: While the selected receiver holds `out_ready` low, `ci_ready` is low and the pending word is neither lost nor reordered. While `co_ready` is low, the sender does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NSVC | Per-service word valid on the send side |
| in_len | input | NSVC×8 | Per-service word count of the message being offered |
| in_data | input | NSVC×CHAN_W | Per-service payload word |
| in_ready | output | NSVC | Per-service word accepted |
| co_valid | output | 1 | Outgoing channel word valid |
| co_data | output | CHAN_W | Outgoing channel word |
| co_ready | input | 1 | Outgoing channel can take a word |
| ci_valid | input | 1 | Incoming channel word valid |
| ci_data | input | CHAN_W | Incoming channel word |
| ci_ready | output | 1 | Incoming word taken |
| out_valid | output | NSVC | Per-service delivered word valid |
| out_ready | input | NSVC | Per-service receiver can take a word |
| out_data | output | CHAN_W | Delivered payload word, shared by all services |
| out_last | output | 1 | Delivered word is the last of its message |

## Verification
The assertions assume that every message a service offers has a nonzero word count. They also assume that `in_len` stays fixed for a service until its header has been taken, and that a service delivers exactly the announced number of words. The stimulus draws message lengths from 1 to 8 and keeps each service's length constant until its header is accepted. It pulls words from per-service queues, so a service never offers more or fewer words than it announced. The stimulus gaps `in_valid`, `ci_valid`, `co_ready` and `out_ready` at random without breaking these rules. On the receive side it deliberately includes zero-count headers and out-of-range service indexes, since the depacketizer must accept both.

// File: rtl/scm_pkg.sv
package scm_pkg;

    typedef enum logic {
        ARB_FIXED  = 1'b0,
        ARB_ROTATE = 1'b1
    } arb_mode_e;

    typedef enum logic {
        PH_HDR  = 1'b0,
        PH_BODY = 1'b1
    } phase_e;

    localparam int SID_W = 4;
    localparam int CNT_W = 8;
    localparam int HDR_W = SID_W + CNT_W;

    typedef struct packed {
        logic [SID_W-1:0] sid;
        logic [CNT_W-1:0] cnt;
    } hdr_t;

    function automatic hdr_t hdr_pack(logic [SID_W-1:0] sid, logic [CNT_W-1:0] cnt);
        hdr_t h;
        h.sid = sid;
        h.cnt = cnt;
        return h;
    endfunction

endpackage

// File: rtl/scm_arbiter.sv
module scm_arbiter
    import scm_pkg::*;
#(
    parameter int        N    = 4,
    parameter arb_mode_e MODE = ARB_FIXED,
    localparam int       IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             upd,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx
);

    logic [IDX_W-1:0] last_q;

    generate
        if (MODE == ARB_ROTATE) begin : g_rot
            always_ff @(posedge clk) begin
                if (rst) last_q <= IDX_W'(N - 1);
                else if (upd) last_q <= gnt_idx;
            end

            always_comb begin
                gnt     = '0;
                gnt_idx = '0;
                for (int k = N - 1; k >= 0; k--) begin
                    int c;
                    c = (int'(last_q) + 1 + k) % N;
                    if (req[c]) begin
                        gnt     = '0;
                        gnt[c]  = 1'b1;
                        gnt_idx = IDX_W'(c);
                    end
                end
            end
        end else begin : g_fix
            assign last_q = '0;

            always_comb begin
                gnt     = '0;
                gnt_idx = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (req[i]) begin
                        gnt     = '0;
                        gnt[i]  = 1'b1;
                        gnt_idx = IDX_W'(i);
                    end
                end
            end
        end
    endgenerate

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt)); // R3
    AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0); // R5
    AST_GNT_WHEN_REQ: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|gnt)); // R6

endmodule

// File: rtl/scm_tx_pack.sv
module scm_tx_pack
    import scm_pkg::*;
#(
    parameter int        N     = 4,
    parameter int        W     = 16,
    parameter arb_mode_e MODE  = ARB_FIXED,
    localparam int       IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N-1:0]             in_valid,
    input  logic [N-1:0][CNT_W-1:0]  in_len,
    input  logic [N-1:0][W-1:0]      in_data,
    output logic [N-1:0]             in_ready,
    output logic                     co_valid,
    output logic [W-1:0]             co_data,
    input  logic                     co_ready
);

    phase_e           phase_q;
    logic [IDX_W-1:0] cur_q;
    logic [CNT_W-1:0] left_q;
    logic [N-1:0]     gnt;
    logic [IDX_W-1:0] gnt_idx;
    logic             hdr_take;
    logic             body_take;

    scm_arbiter #(.N(N), .MODE(MODE)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (in_valid),
        .upd     (hdr_take),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    always_comb begin
        co_valid = 1'b0;
        co_data  = '0;
        in_ready = '0;
        if (phase_q == PH_HDR) begin
            co_valid = |gnt;
            co_data  = W'(hdr_pack(SID_W'(gnt_idx), in_len[gnt_idx]));
        end else begin
            co_valid        = in_valid[cur_q];
            co_data         = in_data[cur_q];
            in_ready[cur_q] = co_ready;
        end
    end

    assign hdr_take  = (phase_q == PH_HDR) && co_valid && co_ready;
    assign body_take = (phase_q == PH_BODY) && in_valid[cur_q] && co_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HDR;
            cur_q   <= '0;
            left_q  <= '0;
        end else if (hdr_take) begin
            phase_q <= PH_BODY;
            cur_q   <= gnt_idx;
            left_q  <= in_len[gnt_idx];
        end else if (body_take) begin
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) phase_q <= PH_HDR;
        end
    end

    AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_ready)); // R3
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BODY && !(body_take && left_q == CNT_W'(1)))
        |=> (phase_q == PH_BODY && cur_q == $past(cur_q))); // R4
    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        hdr_take |-> (in_len[gnt_idx] != '0)); // R2
    AST_TX_STALL: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BODY && !co_ready) |=> $stable(left_q)); // R10

endmodule

// File: rtl/scm_rx_unpack.sv
module scm_rx_unpack
    import scm_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ci_valid,
    input  logic [W-1:0] ci_data,
    output logic         ci_ready,
    output logic [N-1:0] out_valid,
    input  logic [N-1:0] out_ready,
    output logic [W-1:0] out_data,
    output logic         out_last
);

    phase_e           phase_q;
    logic [SID_W-1:0] sid_q;
    logic [CNT_W-1:0] left_q;
    hdr_t             hdr_in;
    logic             known;
    logic             take;

    assign hdr_in   = hdr_t'(ci_data[HDR_W-1:0]);
    assign out_data = ci_data;

    always_comb begin
        known = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sid_q == SID_W'(i)) known = 1'b1;
        end
    end

    always_comb begin
        out_valid = '0;
        out_last  = 1'b0;
        ci_ready  = 1'b1;
        if (phase_q == PH_BODY && known) begin
            ci_ready = 1'b0;
            out_last = (left_q == CNT_W'(1));
            for (int i = 0; i < N; i++) begin
                if (sid_q == SID_W'(i)) begin
                    out_valid[i] = ci_valid;
                    ci_ready     = out_ready[i];
                end
            end
        end
    end

    assign take = ci_valid && ci_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HDR;
            sid_q   <= '0;
            left_q  <= '0;
        end else if (take) begin
            if (phase_q == PH_HDR) begin
                sid_q  <= hdr_in.sid;
                left_q <= hdr_in.cnt;
                if (hdr_in.cnt != '0) phase_q <= PH_BODY;
            end else begin
                left_q <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) phase_q <= PH_HDR;
            end
        end
    end

    AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid)); // R7
    AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (rst)
        (|out_valid) |-> ci_valid); // R7
    AST_RX_STALL: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BODY && ci_valid && !ci_ready)
        |=> (phase_q == PH_BODY && left_q == $past(left_q) && sid_q == $past(sid_q))); // R10
    AST_RX_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BODY && take && left_q != CNT_W'(1))
        |=> (phase_q == PH_BODY && left_q == $past(left_q) - 1'b1)); // R8

endmodule

// File: rtl/svc_chan_mux.sv
module svc_chan_mux
    import scm_pkg::*;
#(
    parameter int        NSVC     = 4,
    parameter int        CHAN_W   = 16,
    parameter arb_mode_e ARB_MODE = ARB_FIXED
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NSVC-1:0]             in_valid,
    input  logic [NSVC-1:0][CNT_W-1:0]  in_len,
    input  logic [NSVC-1:0][CHAN_W-1:0] in_data,
    output logic [NSVC-1:0]             in_ready,
    output logic                        co_valid,
    output logic [CHAN_W-1:0]           co_data,
    input  logic                        co_ready,
    input  logic                        ci_valid,
    input  logic [CHAN_W-1:0]           ci_data,
    output logic                        ci_ready,
    output logic [NSVC-1:0]             out_valid,
    input  logic [NSVC-1:0]             out_ready,
    output logic [CHAN_W-1:0]           out_data,
    output logic                        out_last
);

    scm_tx_pack #(.N(NSVC), .W(CHAN_W), .MODE(ARB_MODE)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_len   (in_len),
        .in_data  (in_data),
        .in_ready (in_ready),
        .co_valid (co_valid),
        .co_data  (co_data),
        .co_ready (co_ready)
    );

    scm_rx_unpack #(.N(NSVC), .W(CHAN_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .ci_valid  (ci_valid),
        .ci_data   (ci_data),
        .ci_ready  (ci_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    AST_TAKE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        ((in_ready & in_valid) != '0) |-> (co_valid && co_ready)); // R3

endmodule

// File: tb/sim_svc_chan_mux.sv
module sim_lane
    import scm_pkg::*;
#(
    parameter arb_mode_e MODE = ARB_FIXED
) (
    input  logic clk,
    input  logic rst,
    output logic done,
    output int   nchk,
    output int   nfail
);
    localparam int N = 4;
    localparam int W = 16;

    logic [N-1:0]          in_valid, in_ready, out_valid, out_ready;
    logic [N-1:0][7:0]     in_len;
    logic [N-1:0][W-1:0]   in_data;
    logic                  co_valid, co_ready, ci_valid, ci_ready, out_last;
    logic [W-1:0]          co_data, ci_data, out_data;

    svc_chan_mux #(.NSVC(N), .CHAN_W(W), .ARB_MODE(MODE)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_len(in_len), .in_data(in_data), .in_ready(in_ready),
        .co_valid(co_valid), .co_data(co_data), .co_ready(co_ready),
        .ci_valid(ci_valid), .ci_data(ci_data), .ci_ready(ci_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    int unsigned wq [N][$];
    int unsigned lq [N][$];
    int unsigned rxq [$];
    int unsigned seq;
    bit [N-1:0]  hide;
    bit          rxgap;
    bit          busy, rhdr;
    int          g, rem, last, rsid, rrem;

    task automatic chk(bit ok, string req, int unsigned act, int unsigned exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual=%0h expected=%0h (%s lane)", req, act, exp,
                     MODE == ARB_ROTATE ? "rotate" : "fixed");
        end
    endtask

    task automatic add_msg(int s, int len);
        lq[s].push_back(len);
        for (int k = 0; k < len; k++) begin
            wq[s].push_back((s << 12) | (seq & 12'hfff));
            seq++;
        end
    endtask

    task automatic add_rx(int sid, int len);
        rxq.push_back((sid << 8) | len);
        for (int k = 0; k < len; k++) begin
            rxq.push_back(16'h8000 | (seq & 16'h7fff));
            seq++;
        end
    endtask

    function automatic int pick(logic [N-1:0] v);
        if (MODE == ARB_FIXED) begin
            for (int i = 0; i < N; i++) if (v[i]) return i;
        end else begin
            for (int k = 1; k <= N; k++) if (v[(last + k) % N]) return (last + k) % N;
        end
        return -1;
    endfunction

    initial begin
        bit rnd;
        done = 0; nchk = 0; nfail = 0; seq = 0;
        busy = 0; rhdr = 1; g = 0; rem = 0; last = N - 1; rsid = 0; rrem = 0;
        hide = '0; rxgap = 0;
        in_valid = '0; in_len = '0; in_data = '0; co_ready = 1'b0;
        ci_valid = 1'b0; ci_data = '0; out_ready = '0;
        while (rst) @(negedge clk);
        #1;
        chk(co_valid == 1'b0, "R1 co_valid", co_valid, 0);
        chk(in_ready == '0, "R1 in_ready", in_ready, 0);
        chk(out_valid == '0, "R1 out_valid", out_valid, 0);
        chk(ci_ready == 1'b1, "R1 ci_ready", ci_ready, 1);

        // receive-side script: normal, zero-count, out-of-range ids
        add_rx(2, 3); add_rx(0, 1); add_rx(3, 0); add_rx(1, 2);
        add_rx(5, 2); add_rx(15, 1); add_rx(3, 4); add_rx(0, 0); add_rx(1, 1);

        for (int cyc = 0; cyc < 3400; cyc++) begin
            @(negedge clk);
            // stimulus
            if (cyc == 2) begin add_msg(3, 2); add_msg(2, 1); add_msg(1, 3); add_msg(0, 2); end
            if (cyc == 50) add_msg(3, 6);
            if (cyc == 53) add_msg(0, 2);
            if (cyc >= 100 && cyc < 3000) begin
                for (int i = 0; i < N; i++)
                    if ($urandom_range(15) == 0 && wq[i].size() < 20) add_msg(i, $urandom_range(1, 8));
                for (int i = 0; i < N; i++) hide[i] = ($urandom_range(7) == 0);
                co_ready = ($urandom_range(3) != 0);
                if ($urandom_range(15) == 0 && rxq.size() < 30) begin
                    rnd = $urandom_range(7) == 0;
                    add_rx(rnd ? $urandom_range(4, 15) : $urandom_range(0, 3), $urandom_range(0, 6));
                end
                rxgap = ($urandom_range(5) == 0);
                for (int i = 0; i < N; i++) out_ready[i] = ($urandom_range(3) != 0);
            end else begin
                hide = '0; rxgap = 0;
                co_ready = (cyc >= 2);
                out_ready = (cyc < 20) ? 4'b0101 : '1;
            end
            for (int i = 0; i < N; i++) begin
                in_valid[i] = (wq[i].size() > 0) && !hide[i];
                in_len[i]   = (lq[i].size() > 0) ? 8'(lq[i][0]) : 8'd0;
                in_data[i]  = (wq[i].size() > 0) ? W'(wq[i][0]) : '0;
            end
            ci_valid = (rxq.size() > 0) && !rxgap;
            ci_data  = (rxq.size() > 0) ? W'(rxq[0]) : '0;
            #1;
            // send-side model
            if (!busy) begin
                int w;
                w = pick(in_valid);
                chk(co_valid == (w >= 0), "R1 header valid", co_valid, w >= 0);
                chk(in_ready == '0, "R3 no ready in header", in_ready, 0);
                if (w >= 0) begin
                    int unsigned eh;
                    eh = (w << 8) | lq[w][0];
                    chk(co_data == W'(eh), MODE == ARB_FIXED ? "R2/R5 header" : "R2/R6 header",
                        co_data, eh);
                    if (co_ready) begin
                        busy = 1; g = w; rem = lq[w][0]; last = w;
                        void'(lq[w].pop_front());
                    end
                end
            end else begin
                logic [N-1:0] er;
                er = co_ready ? (N'(1) << g) : '0;
                chk(co_valid == in_valid[g], "R4 grant held", co_valid, in_valid[g]);
                chk(in_ready == er, "R4/R10 ready to granted", in_ready, er);
                if (in_valid[g]) begin
                    chk(co_data == W'(wq[g][0]), "R3 payload order", co_data, wq[g][0]);
                    if (co_ready) begin
                        void'(wq[g].pop_front());
                        rem--;
                        if (rem == 0) busy = 0;
                    end
                end
            end
            // receive-side model
            if (rhdr) begin
                chk(ci_ready == 1'b1, "R8 header accept", ci_ready, 1);
                chk(out_valid == '0, "R8 no delivery on header", out_valid, 0);
                if (ci_valid) begin
                    rsid = (rxq[0] >> 8) & 15;
                    rrem = rxq[0] & 255;
                    if (rrem != 0) rhdr = 0;
                    void'(rxq.pop_front());
                end
            end else if (rsid >= N) begin
                chk(ci_ready == 1'b1, "R9 discard ready", ci_ready, 1);
                chk(out_valid == '0, "R9 no delivery", out_valid, 0);
                if (ci_valid) begin
                    void'(rxq.pop_front());
                    rrem--;
                    if (rrem == 0) rhdr = 1;
                end
            end else begin
                logic [N-1:0] ev;
                ev = ci_valid ? (N'(1) << rsid) : '0;
                chk(out_valid == ev, "R7 steering", out_valid, ev);
                chk(ci_ready == out_ready[rsid], "R10 backpressure", ci_ready, out_ready[rsid]);
                if (ci_valid) begin
                    chk(out_data == ci_data, "R7 data", out_data, ci_data);
                    chk(out_last == (rrem == 1), "R7 last", out_last, rrem == 1);
                    if (out_ready[rsid]) begin
                        void'(rxq.pop_front());
                        rrem--;
                        if (rrem == 0) rhdr = 1;
                    end
                end
            end
        end
        for (int i = 0; i < N; i++) chk(wq[i].size() == 0, "R3 all words sent", wq[i].size(), 0);
        chk(rxq.size() == 0, "R8 all words received", rxq.size(), 0);
        done = 1;
    end
endmodule

module sim_svc_chan_mux;
    import scm_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic done_a, done_b;
    int   chk_a, chk_b, fail_a, fail_b;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sim_lane #(.MODE(ARB_FIXED))  lane_fix (.clk(clk), .rst(rst), .done(done_a), .nchk(chk_a), .nfail(fail_a));
    sim_lane #(.MODE(ARB_ROTATE)) lane_rot (.clk(clk), .rst(rst), .done(done_b), .nchk(chk_b), .nfail(fail_b));

    initial begin
        int cycles;
        int extra;
        extra = 0;
        cycles = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        while (!(done_a && done_b) && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!(done_a && done_b)) begin
            extra = 1;
            $display("FAIL watchdog: actual=%0d expected=done", cycles);
        end
        $display("== %0d vectors applied, %0d miscompares ==",
                 chk_a + chk_b + extra, fail_a + fail_b + extra);
        $finish;
    end
endmodule